// File: doc/BRIEF.md
# Successive Approximation Register Controller

This block holds the digital half of a successive approximation A/D converter. A start pulse that is sampled high on a clock edge arms the register: every bit is cleared except the top one, which is set as the first trial, and the done flag drops. On each following edge the controller reads a single comparator bit. A 1 means the trial code does not exceed the analog input, so the bit under test is kept. A 0 clears it. The next lower bit is then set as the new trial. The parallel trial outputs drive the current-switch ladder. A serial output repeats each bit in the cycle after it is decided. The done flag rises once the lowest active bit has been decided.

The register can be shortened with a parameter so that only its upper bits take part in a conversion. The outputs can be made active-low for switches that turn on with a low level. A separate enable input acts only on the top trial output, which allows registers to be cascaded. A second parallel output gives the result in two's-complement form by inverting its top bit, for use with an analog side that is offset by half of full range. With `run_cont` high, the register restarts by itself when the done flag is high. It also restarts when the sequencer is in neither the done nor the trial state, so it can never lock up.

Top module: `sar_ctrl`

## Requirements
- R1: A synchronous reset sets `done_o` high and `ser_o` to 0, and makes every trial bit inactive. Inactive is 0, or 1 when ACTIVE_LOW=1.
- R2: When `start` is sampled high, the next cycle shows only the top trial bit set, with `done_o` low. In that cycle `result_tc` reads all zeros.
- R3: On each clock of a conversion, the bit under test is kept when `cmp_in` is 1 and cleared when it is 0. The next lower bit is then set to 1.
- R4: `done_o` rises on the USED_BITS-th edge after the start edge and not earlier. The final code equals the largest trial code that does not exceed the analog input.
- R5: During a conversion, `ser_o` holds the `cmp_in` value that was sampled at the previous edge.
- R6: A `start` sampled high during a conversion restarts the conversion from the top bit.
- R7: While `msb_en` is low, `trial_o[WIDTH-1]` is inactive. The conversion and the other outputs are not affected.
- R8: With ACTIVE_LOW=1, every bit of `trial_o` is the inverse of the logical trial code.
- R9: With USED_BITS below WIDTH, the lowest WIDTH-USED_BITS bits stay at logical 0. The conversion ends after USED_BITS decisions.
- R10: While `run_cont` is high, a new conversion starts at the edge after `done_o` is high, so `done_o` is high for exactly one cycle per conversion.
- R11: `result_tc` equals the logical trial code with its top bit inverted. It does not depend on `msb_en` or on polarity.
- R12: When `done_o` is high and neither `start` nor `run_cont` is high, the code and `done_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a conversion when sampled high |
| run_cont | input | 1 | Free-running mode: restart from done, with lock-up guard |
| cmp_in | input | 1 | Comparator bit, 1 = keep the bit under test |
| msb_en | input | 1 | Enable for the top trial output |
| trial_o | output | WIDTH | Trial/result code to the ladder switches, polarity set by ACTIVE_LOW |
| result_tc | output | WIDTH | Code with top bit inverted (two's-complement view), active-high |
| ser_o | output | 1 | Bit decided at the previous edge |
| done_o | output | 1 | Conversion complete |

## Verification
The hardest situations to reach are a restart that lands in the middle of a conversion and a back-to-back free-running sequence in which a done pulse must last exactly one cycle. The bench reaches both by timing `start` a few edges into a conversion and by holding `run_cont` for several periods. It runs a full-length instance and a truncated active-low instance side by side, so the two periods (13 and 9 edges) drift apart. An ideal comparator in the bench drives `cmp_in` from its own model of the trial code. Any divergence in a single bit therefore changes all later decisions and shows up at once.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef logic [5:0] sar_idx_t;

    typedef enum logic [1:0] {
        MODE_DONE  = 2'b01,
        MODE_TRIAL = 2'b10
    } sar_mode_e;

    typedef struct packed {
        sar_mode_e mode;
        sar_idx_t  idx;
    } sar_state_t;

    function automatic logic in_trial(sar_state_t s);
        return s.mode == MODE_TRIAL;
    endfunction

    function automatic logic in_done(sar_state_t s);
        return s.mode == MODE_DONE;
    endfunction

endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int WIDTH     = 12,
    parameter int USED_BITS = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    output logic       busy,
    output logic       done,
    output logic       last,
    output sar_idx_t   idx
);
    localparam int       LO      = WIDTH - USED_BITS;
    localparam sar_idx_t TOP_IDX = sar_idx_t'(WIDTH - 1);
    localparam sar_idx_t LO_IDX  = sar_idx_t'(LO);

    sar_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.mode <= MODE_DONE;
            st.idx  <= '0;
        end else if (go) begin
            st.mode <= MODE_TRIAL;
            st.idx  <= TOP_IDX;
        end else if (in_trial(st)) begin
            if (st.idx == LO_IDX) begin
                st.mode <= MODE_DONE;
            end else begin
                st.idx <= st.idx - sar_idx_t'(1);
            end
        end
    end

    always_comb begin
        busy = in_trial(st);
        done = in_done(st);
        last = busy && (st.idx == LO_IDX);
        idx  = st.idx;
    end
endmodule

// File: rtl/sar_bits.sv
module sar_bits
    import sar_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             busy,
    input  logic             last,
    input  sar_idx_t         idx,
    input  logic             cmp,
    output logic [WIDTH-1:0] q,
    output logic             ser
);
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] TOPB = ONE << (WIDTH - 1);

    logic [WIDTH-1:0] cur_m;
    logic [WIDTH-1:0] next_m;
    logic [WIDTH-1:0] upd;

    always_comb begin
        cur_m  = ONE << idx;
        next_m = last ? '0 : (cur_m >> 1);
        upd    = (q & ~cur_m) | (cmp ? cur_m : '0) | next_m;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            ser <= 1'b0;
        end else if (go) begin
            q <= TOPB;
        end else if (busy) begin
            q   <= upd;
            ser <= cmp;
        end
    end
endmodule

// File: rtl/sar_outmap.sv
module sar_outmap #(
    parameter int WIDTH      = 12,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic [WIDTH-1:0] q,
    input  logic             msb_en,
    output logic [WIDTH-1:0] trial_o,
    output logic [WIDTH-1:0] result_tc
);
    logic [WIDTH-1:0] gated;

    always_comb begin
        gated            = q;
        gated[WIDTH-1]   = q[WIDTH-1] & msb_en;
        result_tc        = q;
        result_tc[WIDTH-1] = ~q[WIDTH-1];
    end

    generate
        if (ACTIVE_LOW) begin : g_low
            assign trial_o = ~gated;
        end else begin : g_high
            assign trial_o = gated;
        end
    endgenerate
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH      = 12,
    parameter int USED_BITS  = 12,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run_cont,
    input  logic             cmp_in,
    input  logic             msb_en,
    output logic [WIDTH-1:0] trial_o,
    output logic [WIDTH-1:0] result_tc,
    output logic             ser_o,
    output logic             done_o
);
    logic             go;
    logic             busy;
    logic             done;
    logic             last;
    sar_idx_t         idx;
    logic [WIDTH-1:0] q;

    // Free-running restart: from done, or from any state that is neither
    // done nor trial (guards against lock-up).
    assign go = start | (run_cont & (done | ~busy));

    sar_seq #(.WIDTH(WIDTH), .USED_BITS(USED_BITS)) u_seq (
        .clk(clk), .rst(rst), .go(go),
        .busy(busy), .done(done), .last(last), .idx(idx)
    );

    sar_bits #(.WIDTH(WIDTH)) u_bits (
        .clk(clk), .rst(rst), .go(go), .busy(busy), .last(last),
        .idx(idx), .cmp(cmp_in), .q(q), .ser(ser_o)
    );

    sar_outmap #(.WIDTH(WIDTH), .ACTIVE_LOW(ACTIVE_LOW)) u_out (
        .q(q), .msb_en(msb_en), .trial_o(trial_o), .result_tc(result_tc)
    );

    assign done_o = done;
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
    parameter int WIDTH      = 12,
    parameter int USED_BITS  = 12,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             run_cont,
    input logic             cmp_in,
    input logic             msb_en,
    input logic [WIDTH-1:0] trial_o,
    input logic [WIDTH-1:0] result_tc,
    input logic             ser_o,
    input logic             done_o
);
    localparam int   LO     = WIDTH - USED_BITS;
    localparam logic INACT  = ACTIVE_LOW;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (done_o && !ser_o));

    assert_start_msb_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !rst) |=> (!done_o && result_tc == '0));

    assert_serial_bit_R5: assert property (@(posedge clk) disable iff (rst)
        (!rst && !done_o && !start) |=> (ser_o == $past(cmp_in)));

    assert_msb_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !msb_en |-> (trial_o[WIDTH-1] == INACT));

    // R8 and R11: lower trial bits agree with the two's-complement view
    assert_tc_match_R11: assert property (@(posedge clk) disable iff (rst)
        trial_o[WIDTH-2:0] == (ACTIVE_LOW ? ~result_tc[WIDTH-2:0] : result_tc[WIDTH-2:0]));

    assert_cont_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (run_cont && done_o && !rst) |=> !done_o);

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start && !run_cont && !rst) |=> (done_o && $stable(result_tc)));

    generate
        if (LO > 0) begin : g_trunc
            assert_trunc_zero_R9: assert property (@(posedge clk) disable iff (rst)
                result_tc[LO-1:0] == '0);
        end
    endgenerate
endmodule

bind sar_ctrl sar_ctrl_chk #(
    .WIDTH(WIDTH), .USED_BITS(USED_BITS), .ACTIVE_LOW(ACTIVE_LOW)
) u_chk (.*);

// File: tb/sim_sar_ctrl.sv
module sim_sar_ctrl;
    localparam int PERIOD = 10;
    localparam int W      = 12;
    localparam int U1     = 8;

    logic clk = 1'b0;
    logic rst = 1'b1, start = 1'b0, run_cont = 1'b0, msb_en = 1'b1;
    logic cmp0 = 1'b0, cmp1 = 1'b0;
    logic [W-1:0] t0, tc0, t1, tc1;
    logic s0, s1, d0, d1;

    int checks = 0;
    int fails  = 0;
    int tgt[2] = '{0, 0};
    int mq[2]  = '{0, 0};
    int mtok[2] = '{-1, -1};
    int mcc[2] = '{1, 1};
    int mser[2] = '{0, 0};
    int lo[2]  = '{0, W - U1};

    always #(PERIOD/2) clk = ~clk;

    sar_ctrl u0 (
        .clk(clk), .rst(rst), .start(start), .run_cont(run_cont), .cmp_in(cmp0),
        .msb_en(msb_en), .trial_o(t0), .result_tc(tc0), .ser_o(s0), .done_o(d0)
    );

    sar_ctrl #(.USED_BITS(U1), .ACTIVE_LOW(1'b1)) u1 (
        .clk(clk), .rst(rst), .start(start), .run_cont(run_cont), .cmp_in(cmp1),
        .msb_en(msb_en), .trial_o(t1), .result_tc(tc1), .ser_o(s1), .done_o(d1)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    function automatic int exp_trial(int i);
        int v;
        v = mq[i];
        if (!msb_en) v = v & 'h7FF;
        if (i == 1) v = (~v) & 'hFFF;
        return v;
    endfunction

    // behavioural reference, stepped on every edge and compared after it
    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            bit go, bitv;
            go   = start || (run_cont && (mcc[i] != 0 || mtok[i] < 0));
            bitv = (i == 0) ? cmp0 : cmp1;
            if (rst) begin
                mq[i] = 0; mtok[i] = -1; mcc[i] = 1; mser[i] = 0;
            end else if (go) begin
                mq[i] = 'h800; mtok[i] = W - 1; mcc[i] = 0;
            end else if (mtok[i] >= 0) begin
                if (!bitv) mq[i] = mq[i] & ~(1 << mtok[i]);
                mser[i] = bitv;
                if (mtok[i] == lo[i]) begin
                    mtok[i] = -1; mcc[i] = 1;
                end else begin
                    mtok[i] = mtok[i] - 1;
                    mq[i] = mq[i] | (1 << mtok[i]);
                end
            end
        end
        #(PERIOD/4);
        chk(int'(t0) == exp_trial(0), "R3", "u0 trial", int'(t0), exp_trial(0));
        chk(int'(t1) == exp_trial(1), "R3", "u1 trial", int'(t1), exp_trial(1));
        chk(int'(d0) == mcc[0], "R4", "u0 done", int'(d0), mcc[0]);
        chk(int'(d1) == mcc[1], "R4", "u1 done", int'(d1), mcc[1]);
        chk(int'(s0) == mser[0], "R5", "u0 serial", int'(s0), mser[0]);
        chk(int'(s1) == mser[1], "R5", "u1 serial", int'(s1), mser[1]);
        chk(int'(tc0) == (mq[0] ^ 'h800), "R11", "u0 tc", int'(tc0), mq[0] ^ 'h800);
        chk(int'(tc1) == (mq[1] ^ 'h800), "R11", "u1 tc", int'(tc1), mq[1] ^ 'h800);
        // ideal comparator: keep when trial code does not exceed target
        cmp0 = (mq[0] <= tgt[0]);
        cmp1 = (mq[1] <= tgt[1]);
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic conv(input int a, input int b);
        tgt[0] = a; tgt[1] = b;
        start = 1'b1;
        tick(1);
        start = 1'b0;
        chk(int'(t0) == 'h800, "R2", "first trial", int'(t0), 'h800);
        chk(d0 == 1'b0, "R2", "done low", int'(d0), 0);
        for (int k = 1; k <= W; k++) begin
            tick(1);
            if (k == U1 - 1) chk(d1 == 1'b0, "R9", "u1 early done", int'(d1), 0);
            if (k == U1) begin
                chk(d1 == 1'b1, "R9", "u1 done", int'(d1), 1);
                chk(int'(t1) == ((~(b & 'hFF0)) & 'hFFF), "R8", "u1 code",
                    int'(t1), (~(b & 'hFF0)) & 'hFFF);
            end
            if (k == W - 1) chk(d0 == 1'b0, "R4", "u0 early done", int'(d0), 0);
        end
        chk(d0 == 1'b1, "R4", "u0 done", int'(d0), 1);
        chk(int'(tc0 ^ 12'h800) == a, "R4", "u0 code", int'(tc0 ^ 12'h800), a);
    endtask

    initial begin
        int pulses0, pulses1;
        logic p0, p1;
        tick(3);
        chk(d0 == 1'b1, "R1", "done after reset", int'(d0), 1);
        chk(int'(t0) == 0, "R1", "u0 bits", int'(t0), 0);
        chk(int'(t1) == 'hFFF, "R1", "u1 bits inactive", int'(t1), 'hFFF);
        chk(s0 == 1'b0, "R1", "serial", int'(s0), 0);
        rst = 1'b0;
        tick(4);
        chk(d0 == 1'b1 && d1 == 1'b1, "R12", "idle done", int'({d0, d1}), 3);
        chk(int'(tc0) == 'h800, "R12", "idle code", int'(tc0), 'h800);

        conv(0, 0);
        conv('hFFF, 'hFFF);
        conv('h800, 'h00F);
        conv('h7FF, 'hFF0);
        conv('hA5A, 'h5A5);
        conv('h001, 'h7F0);

        // R6: restart in the middle of a conversion
        tgt[0] = 'h123; tgt[1] = 'h456;
        start = 1'b1; tick(1); start = 1'b0;
        tick(5);
        tgt[0] = 'hC71; tgt[1] = 'h9E2;
        start = 1'b1; tick(1); start = 1'b0;
        chk(int'(t0) == 'h800, "R6", "restart trial", int'(t0), 'h800);
        chk(d0 == 1'b0, "R6", "restart done", int'(d0), 0);
        tick(W);
        chk(int'(tc0 ^ 12'h800) == 'hC71, "R6", "restart code", int'(tc0 ^ 12'h800), 'hC71);

        // R7: MSB gate during a conversion
        tgt[0] = 'hFFF; tgt[1] = 'hFFF;
        start = 1'b1; tick(1); start = 1'b0;
        tick(2);
        msb_en = 1'b0;
        tick(1);
        chk(t0[W-1] == 1'b0, "R7", "u0 msb gated", int'(t0[W-1]), 0);
        chk(t1[W-1] == 1'b1, "R7", "u1 msb gated", int'(t1[W-1]), 1);
        chk(tc0[W-1] == 1'b0, "R7", "tc unaffected", int'(tc0[W-1]), 0);
        msb_en = 1'b1;
        tick(W - 3);
        chk(int'(tc0 ^ 12'h800) == 'hFFF, "R7", "code unaffected", int'(tc0 ^ 12'h800), 'hFFF);

        // R10: free-running conversions
        tgt[0] = 'h3C3; tgt[1] = 'hB40;
        pulses0 = 0; pulses1 = 0; p0 = d0; p1 = d1;
        run_cont = 1'b1;
        for (int k = 0; k < 39; k++) begin
            tick(1);
            if (d0 && p0) chk(1'b0, "R10", "u0 done held", 1, 0);
            if (d1 && p1) chk(1'b0, "R10", "u1 done held", 1, 0);
            if (d0) pulses0++;
            if (d1) pulses1++;
            p0 = d0; p1 = d1;
        end
        run_cont = 1'b0;
        chk(pulses0 == 3, "R10", "u0 pulses", pulses0, 3);
        chk(pulses1 == 4, "R10", "u1 pulses", pulses1, 4);
        tick(14);
        chk(d0 && d1, "R10", "stopped", int'({d0, d1}), 3);
        chk(int'(tc0 ^ 12'h800) == 'h3C3, "R10", "u0 code", int'(tc0 ^ 12'h800), 'h3C3);
        chk(int'(tc1 ^ 12'h800) == 'hB40, "R9", "u1 code", int'(tc1 ^ 12'h800), 'hB40);

        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        summary();
        $finish;
    end
endmodule